// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block decides, every cycle, how a classic five-stage load/store pipeline avoids reading stale operands and fetching down the wrong path. It looks at the full instruction word sitting in decode and the full instruction word sitting in execute. It also looks at the destination index, write flag and load flag of the instructions in the memory and write-back stages. The pipeline stages are fetch, decode/register read, execute, memory and write-back.

From these inputs it drives several controls. The first is a pair of operand-bypass selects for the execute stage. The second is a bypass select for the zero comparator that resolves branches in decode. The third is a one-cycle freeze: the program counter and the fetch/decode latch hold, and a bubble enters the decode/execute latch. The last is a squash that turns the instruction being fetched into a no-op when a decode-stage branch or jump is taken.

The controller has no storage. Every output is a function of the current stage contents. The clock and reset only qualify the embedded checks. The data path, the register file and the memories sit outside the block.

Top module: `hazard_unit`

## Requirements
- R1: Instruction fields are decoded from a 32-bit word with opcode in bits 31:26, first source in 25:21 and second source in 20:16. Opcode 0x00 (register-register) reads both sources and writes bits 15:11. Opcode 0x23 (load) reads only the first source and writes bits 20:16. Opcode 0x2B (store) reads both sources and writes nothing. Opcodes 0x04 (branch if zero) and 0x05 (branch if not zero) read only the first source. Opcode 0x02 (jump) reads nothing. Every other opcode is an immediate ALU form that reads the first source and writes bits 20:16.
- R2: An execute-stage operand selects the memory-stage result (select code 2'b10) when the memory stage writes (write flag 1, load flag 0) a nonzero register equal to that operand's source.
- R3: Otherwise the operand selects the write-back result (code 2'b01) when the write-back stage writes a nonzero register equal to that source; else it selects the register file (code 2'b00). Operand A uses the first source and operand B the second.
- R4: When both the memory stage and the write-back stage match an operand, the memory stage wins.
- R5: Register 0 is never bypassed. An operand whose source the execute instruction does not read always selects 2'b00. A memory-stage load is never a bypass source.
- R6: If the execute instruction is a load whose nonzero destination equals a source read by the decode instruction, then pc_hold, ifid_hold and idex_bubble are all 1.
- R7: A conditional branch in decode whose nonzero first source equals the nonzero destination of the execute instruction, or of a memory-stage load (write flag and load flag both 1), also raises all three freeze outputs.
- R8: br_fwd is 1 exactly when a conditional branch in decode has a nonzero first source equal to mem_rd while mem_wen is 1 and mem_load is 0.
- R9: if_squash is 1 when, with no freeze, decode holds a jump, a branch-if-zero with id_opnd_zero=1, or a branch-if-not-zero with id_opnd_zero=0.
- R10: The freeze outputs are 1 only in the R6 and R7 cases, and if_squash is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock qualifying the embedded checks |
| rst_n | input | 1 | Active-low reset for the checks |
| id_instr | input | 32 | Instruction word in the decode stage |
| ex_instr | input | 32 | Instruction word in the execute stage |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination register of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| id_opnd_zero | input | 1 | Decode comparator reports its operand equal to zero |
| fwd_a | output | 2 | Bypass select for execute operand A |
| fwd_b | output | 2 | Bypass select for execute operand B |
| br_fwd | output | 1 | Decode comparator takes the memory-stage result |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode latch |
| idex_bubble | output | 1 | Load a no-op into the decode/execute latch |
| if_squash | output | 1 | Replace the fetched instruction with a no-op |

## Verification
Because the block holds no state, a wrong decode or a wrong priority shows up at the outputs in the same cycle as the offending stage contents. The sweeps therefore run over every opcode class in both decode and execute, register indices 0 to 3, and every combination of stage flags. A missed register-0 guard appears as a nonzero select with a zero index. A swapped priority appears as code 2'b01 where 2'b10 is due. A freeze that leaks into squash appears as both outputs high together.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned OP_LSB  = XLEN - OP_W;
  localparam int unsigned RS1_LSB = OP_LSB - RIDX_W;
  localparam int unsigned RS2_LSB = RS1_LSB - RIDX_W;
  localparam int unsigned RD_LSB  = RS2_LSB - RIDX_W;

  typedef logic [RIDX_W-1:0] ridx_t;
  typedef logic [OP_W-1:0]   opc_t;

  localparam opc_t OPC_REG   = 6'h00;
  localparam opc_t OPC_JMP   = 6'h02;
  localparam opc_t OPC_BEQZ  = 6'h04;
  localparam opc_t OPC_BNEZ  = 6'h05;
  localparam opc_t OPC_LOAD  = 6'h23;
  localparam opc_t OPC_STORE = 6'h2B;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_e;

  typedef struct packed {
    ridx_t src1;
    ridx_t src2;
    logic  use1;
    logic  use2;
    ridx_t dst;
    logic  wr;
    logic  ld;
    logic  brz;
    logic  brnz;
    logic  jmp;
  } dec_t;
endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  opc_t op;
  assign op = instr[XLEN-1:OP_LSB];

  always_comb begin
    dec      = '0;
    dec.src1 = instr[RS1_LSB +: RIDX_W];
    dec.src2 = instr[RS2_LSB +: RIDX_W];
    unique case (op)
      OPC_REG: begin
        dec.use1 = 1'b1;
        dec.use2 = 1'b1;
        dec.dst  = instr[RD_LSB +: RIDX_W];
      end
      OPC_LOAD: begin
        dec.use1 = 1'b1;
        dec.dst  = instr[RS2_LSB +: RIDX_W];
        dec.ld   = 1'b1;
      end
      OPC_STORE: begin
        dec.use1 = 1'b1;
        dec.use2 = 1'b1;
      end
      OPC_BEQZ: begin
        dec.use1 = 1'b1;
        dec.brz  = 1'b1;
      end
      OPC_BNEZ: begin
        dec.use1 = 1'b1;
        dec.brnz = 1'b1;
      end
      OPC_JMP: dec.jmp = 1'b1;
      default: begin
        dec.use1 = 1'b1;
        dec.dst  = instr[RS2_LSB +: RIDX_W];
      end
    endcase
    dec.wr = |dec.dst;
  end
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ridx_t src,
  input  logic  use_src,
  input  ridx_t mem_rd,
  input  logic  mem_wen,
  input  logic  mem_load,
  input  ridx_t wb_rd,
  input  logic  wb_wen,
  output fwd_e  sel
);
  logic live, mem_hit, wb_hit;

  assign live    = use_src && (src != '0);
  assign mem_hit = live && mem_wen && !mem_load && (mem_rd == src);
  assign wb_hit  = live && wb_wen && (wb_rd == src);

  always_comb begin
    sel = FWD_RF;
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
  end

  // R5: a bypass never serves register 0 or an unread source
  p_no_r0_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != FWD_RF) |-> (use_src && src != '0));

  // R4: younger result wins when both later stages match
  p_mem_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_src && src != '0 && mem_wen && !mem_load && mem_rd == src &&
     wb_wen && wb_rd == src) |-> (sel == FWD_MEM));

  // R5: a load in the memory stage is never bypassed
  p_no_load_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FWD_MEM) |-> (mem_wen && !mem_load));
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
  import hz_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  dec_t  id_d,
  input  dec_t  ex_d,
  input  ridx_t mem_rd,
  input  logic  mem_wen,
  input  logic  mem_load,
  input  logic  opnd_zero,
  output logic  stall,
  output logic  squash,
  output logic  br_fwd
);
  logic cond_br, br_live, load_use, br_wait, taken;

  assign cond_br = id_d.brz || id_d.brnz;
  assign br_live = cond_br && (id_d.src1 != '0);

  always_comb begin
    load_use = 1'b0;
    if (ex_d.ld && ex_d.wr) begin
      if (id_d.use1 && id_d.src1 == ex_d.dst) load_use = 1'b1;
      if (id_d.use2 && id_d.src2 == ex_d.dst) load_use = 1'b1;
    end
  end

  always_comb begin
    br_wait = 1'b0;
    if (br_live) begin
      if (ex_d.wr && ex_d.dst == id_d.src1)                   br_wait = 1'b1;
      if (mem_wen && mem_load && mem_rd == id_d.src1)         br_wait = 1'b1;
    end
  end

  assign stall  = load_use || br_wait;
  assign br_fwd = br_live && mem_wen && !mem_load && (mem_rd == id_d.src1);
  assign taken  = id_d.jmp || (id_d.brz && opnd_zero) || (id_d.brnz && !opnd_zero);
  assign squash = taken && !stall;

  // R9: a frozen decode stage never redirects fetch
  p_squash_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !squash);

  // R6: load into a register read next always freezes
  p_load_use_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_d.ld && ex_d.dst != '0 && id_d.use1 && id_d.src1 == ex_d.dst) |-> stall);

  // R8: comparator bypass only from a non-load writer
  p_br_fwd_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_fwd |-> (mem_wen && !mem_load && mem_rd != '0));

  // R10: freeze needs a reader in decode
  p_stall_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (id_d.use1 || id_d.use2));
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hz_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] id_instr,
  input  logic [31:0] ex_instr,
  input  logic [4:0]  mem_rd,
  input  logic        mem_wen,
  input  logic        mem_load,
  input  logic [4:0]  wb_rd,
  input  logic        wb_wen,
  input  logic        id_opnd_zero,
  output logic [1:0]  fwd_a,
  output logic [1:0]  fwd_b,
  output logic        br_fwd,
  output logic        pc_hold,
  output logic        ifid_hold,
  output logic        idex_bubble,
  output logic        if_squash
);
  localparam int unsigned N_OPND = 2;

  dec_t  id_d, ex_d;
  fwd_e  sel [N_OPND];
  ridx_t opnd_src [N_OPND];
  logic  opnd_use [N_OPND];
  logic  stall;

  hz_decode u_dec_id (.instr(id_instr), .dec(id_d));
  hz_decode u_dec_ex (.instr(ex_instr), .dec(ex_d));

  assign opnd_src[0] = ex_d.src1;
  assign opnd_src[1] = ex_d.src2;
  assign opnd_use[0] = ex_d.use1;
  assign opnd_use[1] = ex_d.use2;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hz_fwd_sel u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (opnd_src[g]),
      .use_src (opnd_use[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .mem_load(mem_load),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (sel[g])
    );
  end

  hz_stall_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_d     (id_d),
    .ex_d     (ex_d),
    .mem_rd   (mem_rd),
    .mem_wen  (mem_wen),
    .mem_load (mem_load),
    .opnd_zero(id_opnd_zero),
    .stall    (stall),
    .squash   (if_squash),
    .br_fwd   (br_fwd)
  );

  assign fwd_a       = sel[0];
  assign fwd_b       = sel[1];
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  // R2: operand A bypass from the memory stage names a matching writer
  p_fwd_a_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b10) |-> (mem_rd == ex_instr[25:21]));

  // R3: operand B bypass from write-back names a matching writer
  p_fwd_b_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b == 2'b01) |-> (wb_wen && wb_rd == ex_instr[20:16]));
endmodule

// File: tb/tb_hazard_unit.sv
`timescale 1ns/100ps
module tb_hazard_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] id_instr, ex_instr;
  logic [4:0]  mem_rd, wb_rd;
  logic        mem_wen, mem_load, wb_wen, id_opnd_zero;
  logic [1:0]  fwd_a, fwd_b;
  logic        br_fwd, pc_hold, ifid_hold, idex_bubble, if_squash;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hazard_unit dut (
    .clk(clk), .rst_n(rst_n), .id_instr(id_instr), .ex_instr(ex_instr),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .id_opnd_zero(id_opnd_zero),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .br_fwd(br_fwd), .pc_hold(pc_hold),
    .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .if_squash(if_squash)
  );

  // classes: 0 reg-reg, 1 immediate, 2 load, 3 store, 4 beqz, 5 bnez, 6 jump
  function automatic logic [5:0] opc(int cls);
    case (cls)
      0: return 6'h00;
      1: return 6'h08;
      2: return 6'h23;
      3: return 6'h2B;
      4: return 6'h04;
      5: return 6'h05;
      default: return 6'h02;
    endcase
  endfunction

  function automatic logic [31:0] mk(int cls, int a, int b, int c);
    return {opc(cls), 5'(a), 5'(b), 5'(c), 11'h2A5};
  endfunction

  // R1 reference: what each class reads and writes
  function automatic void ref_dec(int cls, int a, int b, int c,
                                  output int s1, output int s2, output bit u1,
                                  output bit u2, output int dst, output bit ld);
    s1 = a; s2 = b; u1 = 0; u2 = 0; dst = 0; ld = 0;
    case (cls)
      0: begin u1 = 1; u2 = 1; dst = c; end
      1: begin u1 = 1; dst = b; end
      2: begin u1 = 1; dst = b; ld = 1; end
      3: begin u1 = 1; u2 = 1; end
      4, 5: u1 = 1;
      default: ;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_fwd(bit u, int s, int mrd, bit mw, bit ml, int wrd, bit ww);
    if (!u || s == 0) return 0;
    if (mw && !ml && mrd == s) return 2;
    if (ww && wrd == s) return 1;
    return 0;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    id_instr = '0; ex_instr = '0; mem_rd = '0; wb_rd = '0;
    mem_wen = 0; mem_load = 0; wb_wen = 0; id_opnd_zero = 0;
    repeat (3) @(negedge clk);
    // reset state with idle stages: R10
    chk("R10 reset fwd_a", fwd_a, 0);
    chk("R10 reset fwd_b", fwd_b, 0);
    chk("R10 reset freeze", pc_hold | ifid_hold | idex_bubble, 0);
    chk("R10 reset squash", if_squash, 0);
    chk("R8 reset br_fwd", br_fwd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep 1: bypass selects, R1 R2 R3 R4 R5
    for (int ec = 0; ec < 7; ec++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int mr = 0; mr < 4; mr++)
            for (int mf = 0; mf < 4; mf++)
              for (int wr = 0; wr < 4; wr++)
                for (int ww = 0; ww < 2; ww++) begin
                  int s1, s2, dst;
                  bit u1, u2, ld;
                  ref_dec(ec, a, b, 1, s1, s2, u1, u2, dst, ld);
                  id_instr = '0;
                  ex_instr = mk(ec, a, b, 1);
                  mem_rd = 5'(mr); mem_wen = mf[0]; mem_load = mf[1];
                  wb_rd = 5'(wr); wb_wen = ww[0];
                  @(negedge clk);
                  chk("R2/R3/R4/R5 fwd_a", fwd_a,
                      exp_fwd(u1, s1, mr, mf[0], mf[1], wr, ww[0]));
                  chk("R2/R3/R4/R5 fwd_b", fwd_b,
                      exp_fwd(u2, s2, mr, mf[0], mf[1], wr, ww[0]));
                end

    // Sweep 2: freeze, squash and comparator bypass, R1 R6 R7 R8 R9 R10
    wb_rd = '0; wb_wen = 0;
    for (int ic = 0; ic < 7; ic++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int ec = 0; ec < 7; ec++)
            for (int dx = 0; dx < 4; dx++)
              for (int mr = 0; mr < 4; mr++)
                for (int mf = 0; mf < 4; mf++)
                  for (int z = 0; z < 2; z++) begin
                    int is1, is2, idst, es1, es2, edst;
                    bit iu1, iu2, ild, eu1, eu2, eld;
                    bit lu, bw, stl, cbr, tk, bf;
                    ref_dec(ic, a, b, 2, is1, is2, iu1, iu2, idst, ild);
                    ref_dec(ec, 1, dx, dx, es1, es2, eu1, eu2, edst, eld);
                    id_instr = mk(ic, a, b, 2);
                    ex_instr = mk(ec, 1, dx, dx);
                    mem_rd = 5'(mr); mem_wen = mf[0]; mem_load = mf[1];
                    id_opnd_zero = z[0];
                    cbr = (ic == 4 || ic == 5);
                    lu = eld && edst != 0 &&
                         ((iu1 && is1 == edst) || (iu2 && is2 == edst));
                    bw = cbr && is1 != 0 &&
                         ((edst != 0 && edst == is1) ||
                          (mf[0] && mf[1] && mr == is1));
                    stl = lu || bw;
                    bf = cbr && is1 != 0 && mf[0] && !mf[1] && mr == is1;
                    tk = (ic == 6) || (ic == 4 && z == 1) || (ic == 5 && z == 0);
                    @(negedge clk);
                    chk("R6/R7/R10 pc_hold", pc_hold, stl);
                    chk("R6/R7/R10 ifid_hold", ifid_hold, stl);
                    chk("R6/R7/R10 idex_bubble", idex_bubble, stl);
                    chk("R9 if_squash", if_squash, tk && !stl);
                    chk("R8 br_fwd", br_fwd, bf);
                  end

    // Directed corner: both later stages target r3, younger wins (R4)
    id_instr = '0;
    ex_instr = mk(0, 3, 3, 5);
    mem_rd = 5'd3; mem_wen = 1; mem_load = 0; wb_rd = 5'd3; wb_wen = 1;
    @(negedge clk);
    chk("R4 both match a", fwd_a, 2);
    chk("R4 both match b", fwd_b, 2);
    // Directed corner: register 0 writers ignored (R5)
    ex_instr = mk(0, 0, 0, 5);
    mem_rd = 5'd0; wb_rd = 5'd0;
    @(negedge clk);
    chk("R5 r0 a", fwd_a, 0);
    chk("R5 r0 b", fwd_b, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule